// File: doc/BRIEF.md
# Clock-Buffer Configuration Register Slave (I2C, block transfers)

This block is a two-wire serial slave that holds the output-enable configuration of a clock buffer in a small file of seven 8-bit registers. It watches the bus clock and data lines with a much faster system clock, recognises start and stop conditions, and answers one fixed address pair: an even byte for writes and the next odd byte for reads. It pulls the data line low through an open-drain style enable to acknowledge and to return data. All seven registers are presented in parallel on one flat output bus so that the clock-buffer logic can use them directly.

A write always carries two header bytes, a command byte and a count byte. Both are acknowledged and then thrown away. The data that follows always lands in register 0 first and moves up one register per byte. The host may stop after any whole byte. A read returns a count byte first and then every register in ascending order, and the host acknowledges each byte.

The controller is one state machine with twelve states. `ST_IDLE` waits for a start. `ST_ADDR` shifts in the address byte. A matching address leads to `ST_ADDR_ACK`, and any other address leads to `ST_HOLD`. On the write path, `ST_ADDR_ACK` goes to `ST_CMD`, then `ST_CMD_ACK`, then `ST_COUNT`, then `ST_COUNT_ACK`, then `ST_WDATA`. From `ST_WDATA` the machine goes to `ST_WDATA_ACK` and back again for each stored byte, or to `ST_HOLD` once the file is full. On the read path, `ST_ADDR_ACK` goes to `ST_TX_BYTE`, then `ST_TX_ACK`. From `ST_TX_ACK` it returns to `ST_TX_BYTE` when the host acknowledges and registers remain, and goes to `ST_HOLD` otherwise. Three transitions apply in every state: a start goes to `ST_ADDR`, a stop goes to `ST_IDLE`, and reset goes to `ST_IDLE`.

Top module: `clkbuf_i2c_cfg_slave`

## Requirements
- R1: The address byte D4h (write) and the address byte D5h (read) are acknowledged, meaning the slave pulls SDA low during the ninth clock. Any other address gets no acknowledge, and SDA stays released until the next start or stop.
- R2: In a write, the command byte and the count byte that follow the address are each acknowledged. Their values change no register.
- R3: Write data bytes are stored into register 0, then 1, and so on up to 6, and each stored byte is acknowledged. Bits arrive MSB first. Register i appears on `cfg_bytes[8i+7:8i]`.
- R4: A stop after any complete data byte keeps every byte already received. Registers that were not reached keep their earlier values.
- R5: A data byte that arrives after register 6 has been written is not acknowledged and changes no register.
- R6: A read returns the count value 07h first and then registers 0 through 6, each MSB first. SDA changes only while SCL is low.
- R7: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing more until a stop or a start.
- R8: After reset every register bit is 1, so all seven bytes are FFh, and SDA is released.
- R9: A stop in the middle of a byte ends the transfer. The partly received byte is not stored.
- R10: A repeated start, with no stop before it, begins a new transfer. A read that follows it returns the data that was just written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_bytes | output | 56 | Registers 0..6, register i on bits 8i+7:8i |

## Verification
Full seven-byte writes with distinct per-byte values show whether the register index increments and whether the bit order is correct. Partial writes followed by a stop show whether bytes that were never reached keep their old values. An eighth data byte and an address that does not match both test the no-acknowledge paths, and the registers are checked afterwards to confirm nothing changed. A stop in mid-byte and a repeated start from inside a write separate a correct abort from a committed partial byte. A read that the host refuses to acknowledge, on a byte whose MSB is 0, shows whether the slave really lets go of SDA.

// File: rtl/clkbuf_i2c_pkg.sv
package clkbuf_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX_BYTE,
        ST_TX_ACK,
        ST_HOLD
    } slave_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] raw;
    logic [1:0] synced;
    logic       scl_prev;
    logic       sda_prev;

    assign raw = {sda_in, scl_in};

    // one synchronizer chain per bus line, idle level is high
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
            end
        end
        assign synced[g] = chain[STAGES-1];
    end

    assign scl_s = synced[0];
    assign sda_s = synced[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs #(
    parameter int         NUM_BYTES = 7,
    parameter logic [7:0] RESET_VAL = 8'hFF,
    parameter int         IDX_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [7:0]             rd_data,
    output logic [8*NUM_BYTES-1:0] bytes_flat
);

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= RESET_VAL;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                byte_q <= wr_data;
            end
        end
        assign bytes_flat[8*i +: 8] = byte_q;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_data = bytes_flat[8*k +: 8];
            end
        end
    end

    // R5: the controller never requests a write past the last register
    a_r5_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NUM_BYTES)));

endmodule

// File: rtl/clkbuf_i2c_cfg_slave.sv
module clkbuf_i2c_cfg_slave
    import clkbuf_i2c_pkg::*;
#(
    parameter int         NUM_BYTES   = 7,
    parameter logic [7:0] WR_ADDR     = 8'hD4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    output logic [8*NUM_BYTES-1:0] cfg_bytes
);

    localparam int               IDX_W     = $clog2(NUM_BYTES + 1);
    localparam logic [7:0]       RD_ADDR   = WR_ADDR | 8'h01;
    localparam logic [7:0]       COUNT_VAL = 8'(NUM_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_BYTES);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    slave_state_t     state;
    logic [7:0]       shreg;
    logic [3:0]       bit_cnt;
    logic             rd_dir;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] tx_idx;
    logic [7:0]       tx_sr;
    logic             host_ack;
    logic             byte_done;
    logic             wr_en;
    logic [7:0]       rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign wr_en     = (state == ST_WDATA) && byte_done && (wr_idx < LAST_IDX);

    i2c_cfg_regs #(
        .NUM_BYTES (NUM_BYTES),
        .RESET_VAL (8'hFF),
        .IDX_W     (IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (shreg),
        .rd_idx     (tx_idx),
        .rd_data    (rd_data),
        .bytes_flat (cfg_bytes)
    );

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bit_cnt  <= '0;
            rd_dir   <= 1'b0;
            wr_idx   <= '0;
            tx_idx   <= '0;
            tx_sr    <= '0;
            host_ack <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
        end else if (stop_det) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_HOLD: begin
                end
                ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        unique case (state)
                            ST_ADDR: begin
                                if (shreg == WR_ADDR) begin
                                    rd_dir <= 1'b0;
                                    state  <= ST_ADDR_ACK;
                                end else if (shreg == RD_ADDR) begin
                                    rd_dir <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_HOLD;
                                end
                            end
                            ST_CMD:   state <= ST_CMD_ACK;
                            ST_COUNT: state <= ST_COUNT_ACK;
                            default: begin
                                if (wr_idx < LAST_IDX) begin
                                    wr_idx <= wr_idx + IDX_W'(1);
                                    state  <= ST_WDATA_ACK;
                                end else begin
                                    state <= ST_HOLD;
                                end
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rd_dir) begin
                            tx_sr  <= COUNT_VAL;
                            tx_idx <= '0;
                            state  <= ST_TX_BYTE;
                        end else begin
                            state <= ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK: begin
                    if (scl_fall) begin
                        state <= ST_COUNT;
                    end
                end
                ST_COUNT_ACK: begin
                    if (scl_fall) begin
                        wr_idx <= '0;
                        state  <= ST_WDATA;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        state <= ST_WDATA;
                    end
                end
                ST_TX_BYTE: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            state   <= ST_TX_ACK;
                        end else begin
                            tx_sr <= {tx_sr[6:0], 1'b0};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (host_ack && tx_idx < LAST_IDX) begin
                            tx_sr  <= rd_data;
                            tx_idx <= tx_idx + IDX_W'(1);
                            state  <= ST_TX_BYTE;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // output process: open-drain pull on SDA
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_TX_BYTE: sda_oe = ~tx_sr[7];
            default:    sda_oe = 1'b0;
        endcase
    end

    // R6: the slave only moves SDA while the synchronized clock is low
    a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R9: a stop condition always returns the machine to idle
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R3: each stored byte advances the write index by one
    a_r3_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_idx == $past(wr_idx) + IDX_W'(1)));

    // R1, R7: the hold state is left only by a start or a stop
    a_r7_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (state == ST_HOLD || state == ST_IDLE || state == ST_ADDR));

endmodule

// File: tb/clkbuf_i2c_cfg_slave_test.sv
module clkbuf_i2c_cfg_slave_test;

    localparam int NB = 7;
    localparam int Q  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [8*NB-1:0] cfg;

    always #2 clk = ~clk;

    assign sda_bus = sda_h & ~sda_oe;

    clkbuf_i2c_cfg_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_h),
        .sda_in    (sda_bus),
        .sda_oe    (sda_oe),
        .cfg_bytes (cfg)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_v[$];
    string      exp_r[$];
    string      exp_w[$];
    logic [7:0] obs_v[$];
    logic [7:0] shadow [NB];

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic expect_item(string rq, string what, logic [7:0] v);
        exp_r.push_back(rq);
        exp_w.push_back(what);
        exp_v.push_back(v);
    endtask

    task automatic observe(logic [7:0] v);
        obs_v.push_back(v);
    endtask

    // monitor: compares results against the scoreboard as they appear
    initial begin
        forever begin
            wait (obs_v.size() > 0);
            begin
                logic [7:0] o;
                logic [7:0] e;
                string r;
                string w;
                o = obs_v.pop_front();
                checks++;
                if (exp_v.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected result actual=%02h expected=none", o);
                end else begin
                    e = exp_v.pop_front();
                    r = exp_r.pop_front();
                    w = exp_w.pop_front();
                    if (o !== e) begin
                        errors++;
                        $display("FAIL %s %s actual=%02h expected=%02h", r, w, o, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wq();
        scl_h = 1'b1; wq();
        sda_h = 1'b0; wq();
        scl_h = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wq();
        scl_h = 1'b1; wq();
        sda_h = 1'b1; wq();
    endtask

    task automatic write_bit(logic b);
        sda_h = b; wq();
        scl_h = 1'b1; wq(); wq();
        scl_h = 1'b0; wq();
    endtask

    task automatic read_bit(output logic b);
        sda_h = 1'b1; wq();
        scl_h = 1'b1; wq();
        b = sda_bus; wq();
        scl_h = 1'b0; wq();
    endtask

    task automatic send_byte(logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) write_bit(v[i]);
        read_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            v[i] = b;
        end
        write_bit(ack ? 1'b0 : 1'b1);
    endtask

    task automatic send_checked(string rq, string what, logic [7:0] v, logic exp_ack);
        logic a;
        expect_item(rq, what, {7'b0, exp_ack});
        send_byte(v, a);
        observe({7'b0, a});
    endtask

    task automatic check_regs(string rq);
        for (int i = 0; i < NB; i++) begin
            expect_item(rq, $sformatf("reg%0d", i), shadow[i]);
            observe(cfg[8*i +: 8]);
        end
    endtask

    task automatic check_released(string rq);
        expect_item(rq, "sda_oe", 8'h00);
        observe({7'b0, sda_oe});
    endtask

    // full block read with host acknowledging every byte
    task automatic read_all(string rq);
        logic [7:0] v;
        bus_start();
        send_checked("R1", "read address ack", 8'hD5, 1'b1);
        expect_item(rq, "count byte", 8'h07);
        recv_byte(v, 1'b1);
        observe(v);
        for (int i = 0; i < NB; i++) begin
            expect_item(rq, $sformatf("read reg%0d", i), shadow[i]);
            recv_byte(v, 1'b1);
            observe(v);
        end
        bus_stop();
    endtask

    task automatic write_header();
        bus_start();
        send_checked("R1", "write address ack", 8'hD4, 1'b1);
        send_checked("R2", "command ack", 8'h55, 1'b1);
        send_checked("R2", "count ack", 8'hAA, 1'b1);
    endtask

    initial begin
        logic [7:0] v;
        logic b;
        for (int i = 0; i < NB; i++) shadow[i] = 8'hFF;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        wq();

        // R8: reset state
        check_regs("R8");
        check_released("R8");

        // R6: read of reset values
        read_all("R6");

        // R2, R3, R5: full write plus one extra byte
        write_header();
        check_regs("R2");
        for (int i = 0; i < NB; i++) begin
            send_checked("R3", $sformatf("data%0d ack", i), 8'(8'h11 * (i + 1)), 1'b1);
            shadow[i] = 8'(8'h11 * (i + 1));
        end
        check_regs("R3");
        send_checked("R5", "extra byte nack", 8'h99, 1'b0);
        check_regs("R5");
        check_released("R5");
        bus_stop();

        // R4: stop after two bytes
        write_header();
        send_checked("R4", "data0 ack", 8'hA0, 1'b1);
        send_checked("R4", "data1 ack", 8'hB1, 1'b1);
        bus_stop();
        shadow[0] = 8'hA0;
        shadow[1] = 8'hB1;
        check_regs("R4");

        // R6: read back mixed contents
        read_all("R6");

        // R1: unmatched address
        bus_start();
        send_checked("R1", "foreign address nack", 8'hA0, 1'b0);
        send_checked("R1", "byte after nack", 8'h00, 1'b0);
        bus_stop();
        check_regs("R1");

        // R9: stop in the middle of a data byte
        write_header();
        write_bit(1'b1); write_bit(1'b1); write_bit(1'b0); write_bit(1'b0);
        bus_stop();
        check_regs("R9");
        check_released("R9");

        // R10 and R7: write, repeated start, read with host nack
        write_header();
        send_checked("R10", "data0 ack", 8'h5A, 1'b1);
        shadow[0] = 8'h5A;
        bus_start();
        send_checked("R10", "read address ack", 8'hD5, 1'b1);
        expect_item("R10", "count byte", 8'h07);
        recv_byte(v, 1'b1);
        observe(v);
        expect_item("R10", "reg0 after repeated start", 8'h5A);
        recv_byte(v, 1'b0);
        observe(v);
        expect_item("R7", "line after nack", 8'h01);
        read_bit(b);
        observe({7'b0, b});
        check_released("R7");
        bus_stop();
        check_regs("R10");

        wq();
        wait (obs_v.size() == 0);
        repeat (4) @(posedge clk);
        if (exp_v.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard actual=%0d pending expected=0", exp_v.size());
        end
        finish_run();
    end

endmodule